// File: doc/BRIEF.md
# Linked-Pair Reservation Monitor

This block tracks a single address reservation on behalf of one core, so that a linked read followed by a conditional write acts as an atomic read-modify-write. A linked read arms the reservation on its word. A conditional write to that word may commit only if the reservation is still intact. Two things break the reservation: a write by another agent to the same word, and an explicit clear request, for example on an exception return.

For every conditional write, the monitor returns a registered verdict one cycle later. The pass strobe is the memory write enable for that store. The status word is the value written into the store's destination register: 1 when the store commits, 0 when it fails. The reservation is a two-state machine. RSV_IDLE means nothing is reserved and RSV_HELD means a word is reserved. Four transitions are named: TR_ARM (IDLE to HELD on a linked read), TR_REARM (HELD to HELD, a linked read replaces the stored word), TR_DROP (HELD to IDLE on a conditional write, a clear, or a foreign write to the word) and TR_KEEP (no change).

Top module: `llsc_monitor`

## Requirements
- R1: While reset is low, and in the first cycle after it, sc_done, sc_pass and sc_status are all zero. A reservation armed before reset is gone afterwards, so a conditional write to that word fails.
- R2: After a linked read, a conditional write to the same word passes. Address bits below OFS_W (default bits 1:0) are ignored. sc_pass is 1 and sc_status equals exactly 1 in the cycle after the write.
- R3: A conditional write with no reservation held fails: sc_pass 0, sc_status 0.
- R4: A conditional write to a word other than the reserved one fails.
- R5: A foreign write (snoop_we) to the reserved word, at any byte offset, drops the reservation. A foreign write to a different word leaves it intact.
- R6: Every conditional write drops the reservation, whether it passes or fails. A second write to the same word fails.
- R7: A new linked read replaces the reservation. A write to the old word fails and a write to the new word passes.
- R8: clr_req drops the reservation. A conditional write in the same cycle as clr_req fails.
- R9: A foreign write to the reserved word in the same cycle as a conditional write makes that write fail.
- R10: When a linked read and a conditional write share a cycle, the write is judged against the old reservation, and the new linked read then holds the reservation.
- R11: sc_done is 1 in exactly the cycle after each conditional write request and 0 otherwise. sc_pass and sc_status are 0 whenever sc_done is 0.
- R12: A linked read that coincides with a foreign write to the same word does not arm a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_req | input | 1 | Linked read issued this cycle |
| ll_addr | input | ADDR_W | Byte address of the linked read |
| sc_req | input | 1 | Conditional write issued this cycle |
| sc_addr | input | ADDR_W | Byte address of the conditional write |
| snoop_we | input | 1 | Another agent writes memory this cycle |
| snoop_addr | input | ADDR_W | Byte address of that foreign write |
| clr_req | input | 1 | Drop any reservation |
| sc_done | output | 1 | Verdict for the previous cycle's conditional write is valid |
| sc_pass | output | 1 | Conditional write commits (memory write enable) |
| sc_status | output | DATA_W | Value for the destination register: 1 pass, 0 fail |

## Verification
Every verdict is registered once, so sc_done, sc_pass and sc_status belong to the request presented on the single rising edge before they are read. The reservation itself is visible only through later verdicts. The bench drives each step's inputs on a falling edge and reads the outputs on the following falling edge, exactly one rising edge later. Each effect on the reservation (drop, keep, replace) is then checked by the verdict of a later conditional write in the vector table.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [0:0] {
        RSV_IDLE = 1'b0,
        RSV_HELD = 1'b1
    } rsv_state_e;

    typedef enum logic [1:0] {
        TR_KEEP  = 2'd0,
        TR_ARM   = 2'd1,
        TR_REARM = 2'd2,
        TR_DROP  = 2'd3
    } rsv_trans_e;

    localparam int NUM_CMP = 3;
    localparam int CMP_SC_RSV  = 0;
    localparam int CMP_SNP_RSV = 1;
    localparam int CMP_SNP_LL  = 2;

endpackage

// File: rtl/llsc_word_cmp.sv
module llsc_word_cmp #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 2
) (
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [ADDR_W-1:0] addr_b,
    output logic              same_word
);
    localparam int HI = ADDR_W - 1;

    always_comb begin
        same_word = (addr_a[HI:OFS_W] == addr_b[HI:OFS_W]);
    end

endmodule

// File: rtl/llsc_rsv_fsm.sv
module llsc_rsv_fsm
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_req,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_req,
    input  logic              clr_req,
    input  logic              snoop_hit_rsv,
    input  logic              snoop_hit_ll,
    output logic              held,
    output logic [ADDR_W-1:0] rsv_addr
);
    rsv_state_e state_q, state_d;
    rsv_trans_e trans;
    logic [ADDR_W-1:0] addr_q, addr_d;

    // Transition selection: clear first, then linked read, then drops.
    always_comb begin
        trans = TR_KEEP;
        unique case (state_q)
            RSV_IDLE: begin
                if (!clr_req && ll_req && !snoop_hit_ll) trans = TR_ARM;
            end
            RSV_HELD: begin
                if (clr_req)                      trans = TR_DROP;
                else if (ll_req)                  trans = snoop_hit_ll ? TR_DROP : TR_REARM;
                else if (sc_req || snoop_hit_rsv) trans = TR_DROP;
            end
        endcase
    end

    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (trans)
            TR_KEEP:  state_d = state_q;
            TR_ARM,
            TR_REARM: begin
                state_d = RSV_HELD;
                addr_d  = ll_addr;
            end
            TR_DROP:  state_d = RSV_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // Outputs.
    always_comb begin
        held     = (state_q == RSV_HELD);
        rsv_addr = addr_q;
    end

endmodule

// File: rtl/llsc_verdict.sv
module llsc_verdict #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_req,
    input  logic              sc_ok,
    output logic              sc_done,
    output logic              sc_pass,
    output logic [DATA_W-1:0] sc_status
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done   <= 1'b0;
            sc_pass   <= 1'b0;
            sc_status <= '0;
        end else begin
            sc_done   <= sc_req;
            sc_pass   <= sc_req && sc_ok;
            sc_status <= (sc_req && sc_ok) ? DATA_W'(1) : '0;
        end
    end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ll_req,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_req,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              snoop_we,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              clr_req,
    output logic              sc_done,
    output logic              sc_pass,
    output logic [DATA_W-1:0] sc_status
);
    logic              rsv_held;
    logic [ADDR_W-1:0] rsv_addr;
    logic [ADDR_W-1:0] cmp_a [NUM_CMP];
    logic [ADDR_W-1:0] cmp_b [NUM_CMP];
    logic [NUM_CMP-1:0] cmp_hit;
    logic snoop_hit_rsv, snoop_hit_ll, sc_ok;

    always_comb begin
        cmp_a[CMP_SC_RSV]  = sc_addr;
        cmp_b[CMP_SC_RSV]  = rsv_addr;
        cmp_a[CMP_SNP_RSV] = snoop_addr;
        cmp_b[CMP_SNP_RSV] = rsv_addr;
        cmp_a[CMP_SNP_LL]  = snoop_addr;
        cmp_b[CMP_SNP_LL]  = ll_addr;
    end

    for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
        llsc_word_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_cmp (
            .addr_a   (cmp_a[gi]),
            .addr_b   (cmp_b[gi]),
            .same_word(cmp_hit[gi])
        );
    end

    always_comb begin
        snoop_hit_rsv = snoop_we && cmp_hit[CMP_SNP_RSV];
        snoop_hit_ll  = snoop_we && cmp_hit[CMP_SNP_LL];
        sc_ok = rsv_held && cmp_hit[CMP_SC_RSV] && !snoop_hit_rsv && !clr_req;
    end

    llsc_rsv_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ll_req       (ll_req),
        .ll_addr      (ll_addr),
        .sc_req       (sc_req),
        .clr_req      (clr_req),
        .snoop_hit_rsv(snoop_hit_rsv),
        .snoop_hit_ll (snoop_hit_ll),
        .held         (rsv_held),
        .rsv_addr     (rsv_addr)
    );

    llsc_verdict #(.DATA_W(DATA_W)) u_verdict (
        .clk      (clk),
        .rst_n    (rst_n),
        .sc_req   (sc_req),
        .sc_ok    (sc_ok),
        .sc_done  (sc_done),
        .sc_pass  (sc_pass),
        .sc_status(sc_status)
    );

endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFS_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ll_req,
    input logic              sc_req,
    input logic [ADDR_W-1:0] sc_addr,
    input logic              snoop_we,
    input logic [ADDR_W-1:0] snoop_addr,
    input logic              clr_req,
    input logic              held,
    input logic              sc_done,
    input logic              sc_pass,
    input logic [DATA_W-1:0] sc_status
);
    localparam int HI = ADDR_W - 1;

    // R11
    done_follows_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> sc_done);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sc_req |=> (!sc_done && !sc_pass));

    // R3
    no_rsv_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !held) |=> !sc_pass);

    // R8
    clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> (!held && !sc_pass));

    // R6
    sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && !ll_req) |=> !held);

    // R9
    snoop_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_req && snoop_we && (sc_addr[HI:OFS_W] == snoop_addr[HI:OFS_W])) |=> !sc_pass);

    // R2
    status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_status == (sc_pass ? DATA_W'(1) : DATA_W'(0)));

endmodule

bind llsc_monitor llsc_monitor_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .OFS_W (OFS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ll_req    (ll_req),
    .sc_req    (sc_req),
    .sc_addr   (sc_addr),
    .snoop_we  (snoop_we),
    .snoop_addr(snoop_addr),
    .clr_req   (clr_req),
    .held      (rsv_held),
    .sc_done   (sc_done),
    .sc_pass   (sc_pass),
    .sc_status (sc_status)
);

// File: tb/llsc_monitor_bench.sv
`timescale 1ns/1ps
module llsc_monitor_bench;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef logic [57:0] vec_t;

    function automatic vec_t mk(bit ll, bit sc, bit snp, bit clr,
                                logic [15:0] la, logic [15:0] sa, logic [15:0] na,
                                bit ed, bit ep, logic [3:0] rq);
        return {ll, sc, snp, clr, la, sa, na, ed, ep, rq};
    endfunction

    localparam int NV = 33;
    localparam vec_t VEC [NV] = '{
        mk(0,0,0,0, 16'h0000,16'h0000,16'h0000, 0,0, 4'd11), // R11 idle
        mk(0,1,0,0, 16'h0000,16'h0100,16'h0000, 1,0, 4'd3),  // R3 nothing held
        mk(1,0,0,0, 16'h0100,16'h0000,16'h0000, 0,0, 4'd11),
        mk(0,1,0,0, 16'h0000,16'h0103,16'h0000, 1,1, 4'd2),  // R2 offset ignored
        mk(0,1,0,0, 16'h0000,16'h0100,16'h0000, 1,0, 4'd6),  // R6 already consumed
        mk(1,0,0,0, 16'h0200,16'h0000,16'h0000, 0,0, 4'd11),
        mk(0,1,0,0, 16'h0000,16'h0204,16'h0000, 1,0, 4'd4),  // R4 other word
        mk(1,0,0,0, 16'h0300,16'h0000,16'h0000, 0,0, 4'd11),
        mk(0,0,1,0, 16'h0000,16'h0000,16'h0400, 0,0, 4'd5),  // R5 foreign write elsewhere
        mk(0,1,0,0, 16'h0000,16'h0300,16'h0000, 1,1, 4'd5),
        mk(1,0,0,0, 16'h0500,16'h0000,16'h0000, 0,0, 4'd11),
        mk(0,0,1,0, 16'h0000,16'h0000,16'h0502, 0,0, 4'd5),  // R5 foreign write hit
        mk(0,1,0,0, 16'h0000,16'h0500,16'h0000, 1,0, 4'd5),
        mk(1,0,0,0, 16'h0600,16'h0000,16'h0000, 0,0, 4'd11),
        mk(1,0,0,0, 16'h0700,16'h0000,16'h0000, 0,0, 4'd11),
        mk(0,1,0,0, 16'h0000,16'h0700,16'h0000, 1,1, 4'd7),  // R7 new word
        mk(1,0,0,0, 16'h0800,16'h0000,16'h0000, 0,0, 4'd11),
        mk(1,0,0,0, 16'h0900,16'h0000,16'h0000, 0,0, 4'd11),
        mk(0,1,0,0, 16'h0000,16'h0800,16'h0000, 1,0, 4'd7),  // R7 old word
        mk(1,0,0,0, 16'h0A00,16'h0000,16'h0000, 0,0, 4'd11),
        mk(0,0,0,1, 16'h0000,16'h0000,16'h0000, 0,0, 4'd8),  // R8 clear
        mk(0,1,0,0, 16'h0000,16'h0A00,16'h0000, 1,0, 4'd8),
        mk(1,0,0,0, 16'h0B00,16'h0000,16'h0000, 0,0, 4'd11),
        mk(0,1,0,1, 16'h0000,16'h0B00,16'h0000, 1,0, 4'd8),  // R8 same cycle
        mk(1,0,0,0, 16'h0C00,16'h0000,16'h0000, 0,0, 4'd11),
        mk(0,1,1,0, 16'h0000,16'h0C00,16'h0C01, 1,0, 4'd9),  // R9 race
        mk(1,0,0,0, 16'h0D00,16'h0000,16'h0000, 0,0, 4'd11),
        mk(1,1,0,0, 16'h0E00,16'h0D00,16'h0000, 1,1, 4'd10), // R10 old judged
        mk(0,1,0,0, 16'h0000,16'h0E00,16'h0000, 1,1, 4'd10), // R10 new held
        mk(1,0,1,0, 16'h0F00,16'h0000,16'h0F03, 0,0, 4'd12), // R12 race on arm
        mk(0,1,0,0, 16'h0000,16'h0F00,16'h0000, 1,0, 4'd12),
        mk(1,1,0,0, 16'h0110,16'h0120,16'h0000, 1,0, 4'd10),
        mk(0,1,0,0, 16'h0000,16'h0110,16'h0000, 1,1, 4'd10)
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ll_req = 1'b0, sc_req = 1'b0, snoop_we = 1'b0, clr_req = 1'b0;
    logic [ADDR_W-1:0] ll_addr = '0, sc_addr = '0, snoop_addr = '0;
    logic              sc_done, sc_pass;
    logic [DATA_W-1:0] sc_status;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    llsc_monitor #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(2)) u_llsc_monitor (
        .clk(clk), .rst_n(rst_n),
        .ll_req(ll_req), .ll_addr(ll_addr),
        .sc_req(sc_req), .sc_addr(sc_addr),
        .snoop_we(snoop_we), .snoop_addr(snoop_addr),
        .clr_req(clr_req),
        .sc_done(sc_done), .sc_pass(sc_pass), .sc_status(sc_status)
    );

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ll_req = 0; sc_req = 0; snoop_we = 0; clr_req = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        check("R1 done in reset", 32'(sc_done), 0);
        check("R1 pass in reset", 32'(sc_pass), 0);
        rst_n = 1;
        @(negedge clk);
        check("R1 done after reset", 32'(sc_done), 0);
        check("R1 status after reset", sc_status, 0);

        for (int i = 0; i < NV; i++) begin
            vec_t v = VEC[i];
            string rq = $sformatf("R%0d step %0d", v[3:0], i);
            ll_req = v[57]; sc_req = v[56]; snoop_we = v[55]; clr_req = v[54];
            ll_addr = 32'(v[53:38]); sc_addr = 32'(v[37:22]); snoop_addr = 32'(v[21:6]);
            @(negedge clk);
            check(rq, 32'(sc_done), 32'(v[5]));
            check(rq, 32'(sc_pass), 32'(v[4]));
            check(rq, sc_status, 32'(v[4]));
        end
        idle_inputs();
        @(negedge clk);
        check("R11 quiet", 32'(sc_done), 0);

        // R1: reservation lost across reset
        ll_req = 1; ll_addr = 32'h1234;
        @(negedge clk);
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        check("R1 pass after reset", 32'(sc_pass), 0);
        sc_req = 1; sc_addr = 32'h1234;
        @(negedge clk);
        idle_inputs();
        check("R1 done", 32'(sc_done), 1);
        check("R1 fail after reset", 32'(sc_pass), 0);

        // R2: high address bits matter, low two do not
        ll_req = 1; ll_addr = 32'hFFFF_FFFC;
        @(negedge clk);
        idle_inputs();
        sc_req = 1; sc_addr = 32'hFFFF_FFFF;
        @(negedge clk);
        idle_inputs();
        check("R2 top word pass", 32'(sc_pass), 1);
        check("R2 status one", sc_status, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule